// File: doc/BRIEF.md
# Transport Stream Source Emulator

This block produces a synthetic byte stream shaped like the parallel output of a broadcast demodulator. It lets capture logic (a parallel-port sampler feeding a DMA engine, for example) be exercised without a real tuner. Every output is synchronous to the block clock: a byte strobe, a packet-start flag, an error line and an 8-bit data bus.

Two strobe timings are available. In burst timing, the strobe stays high for an entire 188-byte packet and is followed by a programmable idle gap. In sparse timing, each byte gets a single strobe clock, followed by four idle clocks, or by four and five idle clocks alternately. The data can be packet-like, with a sync byte at the start of each packet and a deterministic payload after it. Or it can be a running byte counter, so that a dropped or duplicated byte shows up as a break in the sequence.

Generation starts on a packet boundary when the enable input is raised. Lowering the enable ends the stream after the byte in flight.

Top module: `ts_stream_gen`

## Requirements
- R1: With counter mode off, a packet is 188 strobed bytes. Byte 0 is 0x47. Byte k (1..187) is (P + k) mod 256, where P is the number of complete 188-byte packets emitted since reset, counted mod 256.
- R2: `ts_sop` is high only together with `ts_valid`, and only on byte 0 of each packet.
- R3: In burst timing, `ts_valid` is high for 188 consecutive clocks. It is then low for max(`burst_gap`,1) clocks before the next packet.
- R4: In sparse timing, every strobe lasts one clock and is followed by idle clocks. The j-th byte since enable (j from 0) is followed by 4 idle clocks when `gap_alt`=0, and by 4 + (j mod 2) idle clocks when `gap_alt`=1.
- R5: With counter mode on, each strobed byte carries a counter. The counter is 0 after reset, advances by 1 mod 256 only on bytes strobed in counter mode, and keeps its value across runs. `ts_sop` still marks packet starts.
- R6: `ts_err` is always low.
- R7: Enable behaviour:
  - When the block is idle, enable sampled high at a clock edge makes the next clock carry byte 0 of a new packet, with `ts_sop` high.
  - Enable sampled low at an edge ends the stream: no further strobe follows, and a partly sent packet does not count toward P.
- R8: `sparse_mode` and `count_mode` take effect only at packet boundaries. They are sampled while idle and on the last byte of a packet, so a change in mid-packet does not alter the rest of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start/continue generation |
| sparse_mode | input | 1 | 1 = one-clock strobe per byte, 0 = whole-packet strobe |
| count_mode | input | 1 | 1 = counter payload, 0 = packet payload |
| gap_alt | input | 1 | Sparse timing: alternate 4/5 idle clocks |
| burst_gap | input | GAP_W | Burst timing idle clocks between packets (0 treated as 1) |
| ts_valid | output | 1 | Byte strobe |
| ts_sop | output | 1 | Packet start flag |
| ts_err | output | 1 | Error line, held low |
| ts_data | output | 8 | Byte value |

## Verification
The assertions check the following on every cycle:
- A start flag never appears without a strobe, and it always follows an idle clock.
- In packet data mode, the start byte is the sync value.
- A sparse strobe never lasts two clocks.
- Consecutive counter-mode bytes always differ by exactly one.

The bench scenarios are needed for the exact gap lengths, the 4/5 alternation, the payload values tied to the packet sequence, truncation on disable, and the deferral of mode changes to the next packet boundary. They compare every cycle against an arithmetic timeline built from the run's settings.

// File: rtl/ts_stream_gen.sv
module ts_stream_gen #(
  parameter int         PKT_LEN    = 188,
  parameter logic [7:0] SYNC_BYTE  = 8'h47,
  parameter int         GAP_W      = 8,
  parameter int         SPARSE_GAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sparse_mode,
  input  logic             count_mode,
  input  logic             gap_alt,
  input  logic [GAP_W-1:0] burst_gap,
  output logic             ts_valid,
  output logic             ts_sop,
  output logic             ts_err,
  output logic [7:0]       ts_data
);

  localparam int IDX_W = $clog2(PKT_LEN);
  localparam int SG_W  = $clog2(SPARSE_GAP + 2);
  localparam int CNT_W = (GAP_W > SG_W) ? GAP_W : SG_W;

  typedef enum logic [1:0] {S_IDLE, S_BYTE, S_GAP} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic [7:0]       seq;
  logic [7:0]       cnt;
  logic [CNT_W-1:0] gap_cnt;
  logic             m_sparse;
  logic             m_count;
  logic             phase;

  wire last = (idx == IDX_W'(PKT_LEN - 1));
  wire boundary = (st == S_IDLE) || (st == S_BYTE && last);
  wire [CNT_W-1:0] burst_len =
    (burst_gap == '0) ? '0 : CNT_W'(burst_gap - GAP_W'(1));
  wire [CNT_W-1:0] sparse_len =
    CNT_W'(SPARSE_GAP - 1) + CNT_W'(gap_alt & phase);

  assign ts_valid = (st == S_BYTE);
  assign ts_sop   = ts_valid && (idx == '0);
  assign ts_err   = 1'b0;
  assign ts_data  = m_count ? cnt :
                    (idx == '0) ? SYNC_BYTE : seq + 8'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      seq      <= '0;
      cnt      <= '0;
      gap_cnt  <= '0;
      m_sparse <= 1'b0;
      m_count  <= 1'b0;
      phase    <= 1'b0;
    end else begin
      if (boundary) begin
        m_sparse <= sparse_mode;
        m_count  <= count_mode;
      end
      case (st)
        S_IDLE: begin
          idx   <= '0;
          phase <= 1'b0;
          if (enable) st <= S_BYTE;
        end
        S_BYTE: begin
          if (m_count) cnt <= cnt + 8'd1;
          if (last) begin
            idx <= '0;
            seq <= seq + 8'd1;
          end else begin
            idx <= idx + IDX_W'(1);
          end
          phase <= ~phase;
          if (!enable) begin
            st <= S_IDLE;
          end else if (m_sparse) begin
            st      <= S_GAP;
            gap_cnt <= sparse_len;
          end else if (last) begin
            st      <= S_GAP;
            gap_cnt <= burst_len;
          end
        end
        S_GAP: begin
          if (!enable)              st <= S_IDLE;
          else if (gap_cnt == '0)   st <= S_BYTE;
          else                      gap_cnt <= gap_cnt - CNT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ts_stream_gen_chk.sv
module ts_stream_gen_chk #(
  parameter logic [7:0] SYNC_BYTE = 8'h47
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ts_valid,
  input logic       ts_sop,
  input logic [7:0] ts_data,
  input logic       m_sparse,
  input logic       m_count
);

  logic       seen;
  logic [7:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      prev <= '0;
    end else if (ts_valid && m_count) begin
      seen <= 1'b1;
      prev <= ts_data;
    end
  end

  p_sop_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ts_sop |-> ts_valid);

  p_sync_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_sop && !m_count) |-> (ts_data == SYNC_BYTE));

  p_sop_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ts_sop |-> !$past(ts_valid));

  p_sparse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && m_sparse) |=> !ts_valid);

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && m_count && seen) |-> (ts_data == prev + 8'd1));

endmodule

bind ts_stream_gen ts_stream_gen_chk #(.SYNC_BYTE(SYNC_BYTE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ts_valid (ts_valid),
  .ts_sop   (ts_sop),
  .ts_data  (ts_data),
  .m_sparse (m_sparse),
  .m_count  (m_count)
);

// File: tb/tb_ts_stream_gen.sv
`timescale 1ns/100ps
module tb_ts_stream_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       sparse_mode = 1'b0;
  logic       count_mode = 1'b0;
  logic       gap_alt = 1'b0;
  logic [7:0] burst_gap = 8'd0;
  logic       ts_valid, ts_sop, ts_err;
  logic [7:0] ts_data;

  int vec = 0;
  int bad = 0;
  int pkt_base = 0;
  int cnt_base = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ts_stream_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sparse_mode(sparse_mode),
    .count_mode(count_mode), .gap_alt(gap_alt), .burst_gap(burst_gap),
    .ts_valid(ts_valid), .ts_sop(ts_sop), .ts_err(ts_err), .ts_data(ts_data)
  );

  task automatic idle_check(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      vec++;
      if (ts_valid !== 1'b0 || ts_sop !== 1'b0 || ts_err !== 1'b0) begin
        bad++;
        $display("FAIL %s idle: valid=%b sop=%b err=%b expected 0 0 0",
                 req, ts_valid, ts_sop, ts_err);
      end
    end
  endtask

  task automatic run(input bit sp, input bit cm, input bit alt, input int g,
                     input int ncyc, input int flip_at);
    int gl = (g < 1) ? 1 : g;
    int per = 188 + gl;
    int bytes = 0;
    int next_t = 0;
    sparse_mode = sp; count_mode = cm; gap_alt = alt; burst_gap = 8'(g);
    enable = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      bit ev, es;
      logic [7:0] ed;
      int j;
      string req;
      @(posedge clk); #1;
      j  = bytes;
      ev = sp ? (n == next_t) : ((n % per) < 188);
      es = ev && (j % 188 == 0);
      ed = cm ? 8'(cnt_base + j)
              : ((j % 188 == 0) ? 8'h47 : 8'(pkt_base + j / 188 + j % 188));
      vec++;
      if (ts_valid !== ev || ts_sop !== es || ts_err !== 1'b0 ||
          (ev && ts_data !== ed)) begin
        bad++;
        if (flip_at >= 0 && n > flip_at) req = "R8";
        else if (n == 0)                 req = "R7";
        else if (ts_err !== 1'b0)        req = "R6";
        else if (ts_valid !== ev)        req = sp ? "R4" : "R3";
        else if (ts_sop !== es)          req = "R2";
        else                             req = cm ? "R5" : "R1";
        $display("FAIL %s cycle %0d: valid=%b sop=%b err=%b data=%h expected %b %b 0 %h",
                 req, n, ts_valid, ts_sop, ts_err, ts_data, ev, es, ed);
      end
      if (ev) begin
        bytes++;
        if (sp) next_t = n + 1 + 4 + ((alt && (j % 2 == 1)) ? 1 : 0);
      end
      if (n == flip_at) begin
        sparse_mode = ~sp;
        count_mode  = ~cm;
      end
      if (n == ncyc - 1) enable = 1'b0;
    end
    pkt_base += bytes / 188;
    if (cm) cnt_base += bytes;
    idle_check(6, "R7");
  endtask

  initial begin
    #1;
    vec++;
    if (ts_valid !== 1'b0 || ts_sop !== 1'b0 || ts_err !== 1'b0) begin
      bad++;
      $display("FAIL R6 reset: valid=%b sop=%b err=%b expected 0 0 0",
               ts_valid, ts_sop, ts_err);
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle_check(5, "R7");

    for (int sp = 0; sp < 2; sp++)
      for (int cm = 0; cm < 2; cm++) begin
        if (sp == 0) begin
          run(1'b0, cm[0], 1'b0, 0, 500, -1);
          run(1'b0, cm[0], 1'b0, 1, 500, -1);
          run(1'b0, cm[0], 1'b1, 3, 470, -1);
          run(1'b0, cm[0], 1'b0, 9, 520, -1);
        end else begin
          run(1'b1, cm[0], 1'b0, 0, 2200, -1);
          run(1'b1, cm[0], 1'b1, 2, 2203, -1);
        end
      end
    // R8: mid-packet mode flip must not affect the packet in flight
    run(1'b0, 1'b0, 1'b0, 2, 188, 50);
    run(1'b1, 1'b1, 1'b1, 0, 60, 20);
    run(1'b0, 1'b0, 1'b0, 5, 400, -1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule